// File: doc/BRIEF.md
# Vector Indexed Aligned Load Unit

This unit executes one indexed 16-byte vector load. It accepts an instruction word on a start pulse and recognises two encodings: a classic one with a 5-bit destination vector index, and an extended one whose 7-bit destination index is split across two fields. It reads a base and an index operand through a 64-bit general-register read port. It forms a 16-byte-aligned address, reads the 16 bytes one per cycle over a byte-wide memory port and packs them big-endian into a 128-bit word. The unit then hands that word, the destination index and PC+4 to the vector register file.

A base field of zero selects the constant zero instead of register 0. A misaligned sum is rounded down to the 16-byte boundary and never raises a fault. The cache-replacement hint carried by the instruction has no effect on the data. A word that matches neither encoding gives a one-cycle illegal flag and causes no memory traffic.

Top module: `vload_unit`

## Requirements
- R1: A word with (insn & 0xFC0007FE) == 0x7C0002CE is accepted as the classic form, and its destination index is insn[25:21] zero-extended to 7 bits.
- R2: A word with (insn & 0xFC0007F3) == 0x100002C3 is accepted as the extended form, and its destination index is {insn[3:2], insn[25:21]}, covering v0..v127.
- R3: A start with a word matching neither form raises `illegal` for exactly the following cycle, issues no memory read and produces no vector write.
- R4: The base field insn[20:16] drives `gpr_ra_idx` and the index field insn[15:11] drives `gpr_rb_idx`. When the base field is 0, the base value is zero whatever `gpr_ra_data` holds.
- R5: The effective address is the low 32 bits of the wrapping 64-bit sum base + index, with bits 3:0 cleared. The unit reads the addresses EA, EA+1, ..., EA+15 in order, one per cycle, in the 16 cycles that follow the start cycle.
- R6: The byte read from EA+k is placed in `vr_data[127-8k -: 8]`, so the byte at EA is the most significant byte.
- R7: `done` and `vr_we` are high together for one cycle, 17 cycles after the start edge. In that cycle `vr_idx` and `vr_data` are valid and `next_pc` equals the start-cycle `pc` + 4.
- R8: A start while `busy` is high is ignored. The ongoing load keeps its index, its data and its count of 16 reads, and gives a single completion pulse.
- R9: A synchronous active-high reset returns the unit to idle: `busy`, `mem_rd_en`, `done`, `vr_we` and `illegal` are all low and no write is pending.
- R10: In the classic form, bit insn[0] is ignored, so words with it set are accepted and give the same result.
- R11: A start in the same cycle as `done` is accepted, so loads can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, sampled when idle |
| insn | input | 32 | Instruction word, valid with start |
| pc | input | 64 | Program counter of the instruction, valid with start |
| gpr_ra_idx | output | 5 | Register number for the base operand |
| gpr_rb_idx | output | 5 | Register number for the index operand |
| gpr_ra_data | input | 64 | Base register value, combinational from gpr_ra_idx |
| gpr_rb_data | input | 64 | Index register value, combinational from gpr_rb_idx |
| mem_rd_en | output | 1 | Byte read request |
| mem_addr | output | 32 | Byte read address |
| mem_rdata | input | 8 | Read byte, returned the cycle after the request |
| busy | output | 1 | Load in progress |
| illegal | output | 1 | One-cycle flag for an unrecognised word |
| done | output | 1 | Completion pulse |
| vr_we | output | 1 | Vector register write enable |
| vr_idx | output | 7 | Destination vector register index |
| vr_data | output | 128 | Loaded vector, big-endian lanes |
| next_pc | output | 64 | PC + 4 of the completed instruction |

## Verification
Two events can fall in the same cycle: the completion pulse of one load and the start of the next one. The bench launches a second instruction in exactly the cycle where `done` is seen. It then checks that the first result is intact, and that the second load issues its own 16 aligned reads and completes 17 cycles later with its own index and data. The bench also fires a start in the middle of a load and requires that it has no effect on the reads, the index or the number of completion pulses.

// File: rtl/vload_pkg.sv
package vload_pkg;

   localparam int INSN_W   = 32;
   localparam int REG_W    = 5;
   localparam int VIDX_W   = 7;

   localparam logic [31:0] CLASSIC_MASK  = 32'hFC00_07FE;
   localparam logic [31:0] CLASSIC_MATCH = 32'h7C00_02CE;
   localparam logic [31:0] EXT_MASK      = 32'hFC00_07F3;
   localparam logic [31:0] EXT_MATCH     = 32'h1000_02C3;

   typedef struct packed {
      logic                hit;
      logic                ext;
      logic [REG_W-1:0]    ra;
      logic [REG_W-1:0]    rb;
      logic [VIDX_W-1:0]   vidx;
   } vld_dec_t;

endpackage

// File: rtl/vload_decode.sv
module vload_decode
   import vload_pkg::*;
#(
   parameter bit EXT_EN = 1'b1
) (
   input  logic [INSN_W-1:0] insn,
   output vld_dec_t          dec
);

   logic classic_hit;
   logic ext_hit;

   assign classic_hit = (insn & CLASSIC_MASK) == CLASSIC_MATCH;

   generate
      if (EXT_EN) begin : g_ext
         assign ext_hit = (insn & EXT_MASK) == EXT_MATCH;
      end else begin : g_no_ext
         assign ext_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      dec.hit = classic_hit | ext_hit;
      dec.ext = ext_hit;
      dec.ra  = insn[20:16];
      dec.rb  = insn[15:11];
      if (ext_hit) begin
         dec.vidx = {insn[3:2], insn[25:21]};
      end else begin
         dec.vidx = {2'b00, insn[25:21]};
      end
   end

endmodule

// File: rtl/vload_agen.sv
module vload_agen #(
   parameter int GPR_W  = 64,
   parameter int ADDR_W = 32,
   parameter int LANES  = 16
) (
   input  logic              ra_is_zero,
   input  logic [GPR_W-1:0]  ra_val,
   input  logic [GPR_W-1:0]  rb_val,
   output logic [ADDR_W-1:0] ea
);

   localparam int OFS_W = $clog2(LANES);

   generate
      if (ADDR_W > GPR_W) begin : g_bad_width
         $error("vload_agen: ADDR_W must not exceed GPR_W");
      end
   endgenerate

   logic [GPR_W-1:0] base;
   logic [GPR_W-1:0] sum;

   always_comb begin
      base = ra_is_zero ? '0 : ra_val;
      sum  = base + rb_val;
      ea   = {sum[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
   end

endmodule

// File: rtl/vload_seq.sv
module vload_seq #(
   parameter int ADDR_W = 32,
   parameter int LANES  = 16
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 go,
   input  logic [ADDR_W-1:0]    ea,
   input  logic [7:0]           mem_rdata,
   output logic                 busy,
   output logic                 mem_rd_en,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic                 done,
   output logic [LANES*8-1:0]   data
);

   localparam int                 OFS_W = $clog2(LANES);
   localparam logic [OFS_W-1:0]   LAST  = OFS_W'(LANES - 1);

   generate
      if ((1 << OFS_W) != LANES || LANES < 2) begin : g_bad_lanes
         $error("vload_seq: LANES must be a power of two of at least 2");
      end
   endgenerate

   logic              issuing;
   logic [OFS_W-1:0]  issue_cnt;
   logic [ADDR_W-1:0] base_q;
   logic              cap_vld;
   logic [OFS_W-1:0]  cap_lane;
   logic              done_q;
   logic [7:0]        lane_q [LANES];

   assign busy      = issuing | cap_vld;
   assign mem_rd_en = issuing;
   assign mem_addr  = {base_q[ADDR_W-1:OFS_W], issue_cnt};
   assign done      = done_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         issuing   <= 1'b0;
         issue_cnt <= '0;
         base_q    <= '0;
         cap_vld   <= 1'b0;
         cap_lane  <= '0;
         done_q    <= 1'b0;
      end else begin
         if (go && !busy) begin
            issuing   <= 1'b1;
            issue_cnt <= '0;
            base_q    <= ea;
         end else if (issuing) begin
            issue_cnt <= issue_cnt + 1'b1;
            if (issue_cnt == LAST) begin
               issuing <= 1'b0;
            end
         end
         cap_vld  <= issuing;
         cap_lane <= issue_cnt;
         done_q   <= cap_vld && (cap_lane == LAST);
      end
   end

   genvar k;
   generate
      for (k = 0; k < LANES; k++) begin : g_lane
         always_ff @(posedge clk) begin
            if (rst) begin
               lane_q[k] <= 8'h00;
            end else if (cap_vld && cap_lane == OFS_W'(k)) begin
               lane_q[k] <= mem_rdata;
            end
         end
         assign data[(LANES-1-k)*8 +: 8] = lane_q[k];
      end
   endgenerate

   p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
      (mem_rd_en && $past(mem_rd_en) && !$past(rst)) |-> (mem_addr == $past(mem_addr) + 1'b1));

   p_first_aligned_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(mem_rd_en) |-> (mem_addr[OFS_W-1:0] == '0));

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   p_done_after_reads_r7: assert property (@(posedge clk) disable iff (rst)
      done |-> (!mem_rd_en && !busy));

endmodule

// File: rtl/vload_unit.sv
module vload_unit
   import vload_pkg::*;
#(
   parameter int GPR_W  = 64,
   parameter int ADDR_W = 32,
   parameter int PC_W   = 64,
   parameter int LANES  = 16,
   parameter bit EXT_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 start,
   input  logic [INSN_W-1:0]    insn,
   input  logic [PC_W-1:0]      pc,
   output logic [REG_W-1:0]     gpr_ra_idx,
   output logic [REG_W-1:0]     gpr_rb_idx,
   input  logic [GPR_W-1:0]     gpr_ra_data,
   input  logic [GPR_W-1:0]     gpr_rb_data,
   output logic                 mem_rd_en,
   output logic [ADDR_W-1:0]    mem_addr,
   input  logic [7:0]           mem_rdata,
   output logic                 busy,
   output logic                 illegal,
   output logic                 done,
   output logic                 vr_we,
   output logic [VIDX_W-1:0]    vr_idx,
   output logic [LANES*8-1:0]   vr_data,
   output logic [PC_W-1:0]      next_pc
);

   localparam logic [PC_W-1:0] PC_STEP = PC_W'(4);

   vld_dec_t          dec;
   logic [ADDR_W-1:0] ea;
   logic              accept;
   logic              illegal_q;
   logic [VIDX_W-1:0] vidx_q;
   logic [PC_W-1:0]   npc_q;
   logic              seq_done;

   vload_decode #(.EXT_EN(EXT_EN)) u_dec (
      .insn (insn),
      .dec  (dec)
   );

   assign gpr_ra_idx = dec.ra;
   assign gpr_rb_idx = dec.rb;

   vload_agen #(.GPR_W(GPR_W), .ADDR_W(ADDR_W), .LANES(LANES)) u_agen (
      .ra_is_zero (dec.ra == '0),
      .ra_val     (gpr_ra_data),
      .rb_val     (gpr_rb_data),
      .ea         (ea)
   );

   assign accept = start && !busy && dec.hit;

   vload_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) u_seq (
      .clk       (clk),
      .rst       (rst),
      .go        (accept),
      .ea        (ea),
      .mem_rdata (mem_rdata),
      .busy      (busy),
      .mem_rd_en (mem_rd_en),
      .mem_addr  (mem_addr),
      .done      (seq_done),
      .data      (vr_data)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         illegal_q <= 1'b0;
         vidx_q    <= '0;
         npc_q     <= '0;
      end else begin
         illegal_q <= start && !busy && !dec.hit;
         if (accept) begin
            vidx_q <= dec.vidx;
            npc_q  <= pc + PC_STEP;
         end
      end
   end

   assign illegal = illegal_q;
   assign done    = seq_done;
   assign vr_we   = seq_done;
   assign vr_idx  = vidx_q;
   assign next_pc = npc_q;

   p_illegal_quiet_r3: assert property (@(posedge clk) disable iff (rst)
      illegal |-> (!mem_rd_en && !vr_we));

   p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (busy && start) |=> (vr_idx == $past(vr_idx) && next_pc == $past(next_pc)));

   p_reset_idle_r9: assert property (@(posedge clk)
      $past(rst) |-> (!busy && !mem_rd_en && !vr_we && !illegal));

endmodule

// File: tb/vload_unit_bench.sv
module vload_unit_bench;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          start = 1'b0;
   logic [31:0]   insn = '0;
   logic [63:0]   pc = '0;
   logic [4:0]    gpr_ra_idx, gpr_rb_idx;
   logic [63:0]   gpr_ra_data, gpr_rb_data;
   logic          mem_rd_en;
   logic [31:0]   mem_addr;
   logic [7:0]    mem_rdata = '0;
   logic          busy, illegal, done, vr_we;
   logic [6:0]    vr_idx;
   logic [127:0]  vr_data;
   logic [63:0]   next_pc;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;
   logic [63:0] salt = 64'h0;
   int rd_total = 0;
   logic [31:0] addr_log [64];

   always #4 clk = ~clk;

   vload_unit u_vload_unit (
      .clk(clk), .rst(rst), .start(start), .insn(insn), .pc(pc),
      .gpr_ra_idx(gpr_ra_idx), .gpr_rb_idx(gpr_rb_idx),
      .gpr_ra_data(gpr_ra_data), .gpr_rb_data(gpr_rb_data),
      .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .busy(busy), .illegal(illegal), .done(done), .vr_we(vr_we),
      .vr_idx(vr_idx), .vr_data(vr_data), .next_pc(next_pc)
   );

   function automatic logic [63:0] gv(input logic [4:0] i);
      return {32'hFFFF_FF00 ^ {27'd0, i}, 32'hFFFF_FFF3 - {i, 24'h0}} ^ salt;
   endfunction

   function automatic logic [7:0] mb(input logic [31:0] a);
      return (a[7:0] * 8'h1D) ^ a[15:8] ^ a[31:24] ^ 8'h3C;
   endfunction

   always_comb begin
      gpr_ra_data = gv(gpr_ra_idx);
      gpr_rb_data = gv(gpr_rb_idx);
   end

   always @(posedge clk) begin
      if (mem_rd_en) begin
         mem_rdata <= mb(mem_addr);
         addr_log[rd_total % 64] <= mem_addr;
         rd_total <= rd_total + 1;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_ea(input logic [31:0] w);
      logic [63:0] base;
      logic [63:0] s;
      base = (w[20:16] == 5'd0) ? 64'd0 : gv(w[20:16]);
      s = base + gv(w[15:11]);
      return {s[31:4], 4'h0};
   endfunction

   int rd_mark = 0;

   task automatic launch(input logic [31:0] w);
      start = 1'b1;
      insn  = w;
      rd_mark = rd_total;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic finish(input logic [31:0] w, input logic [6:0] eidx, input string itag,
                         input int cnt0, input logic [63:0] epc);
      int cnt;
      logic [31:0] ea;
      logic [127:0] ed;
      cnt = cnt0;
      while (!done && cnt < 40) begin
         @(negedge clk);
         cnt++;
      end
      ea = exp_ea(w);
      for (int k = 0; k < 16; k++) ed[127-8*k -: 8] = mb(ea + k);
      chk(cnt == 18, "R7 latency", 128'(cnt), 128'd18);
      chk(vr_we == 1'b1, "R7 write enable", 128'(vr_we), 128'd1);
      chk(next_pc == epc + 64'd4, "R7 next pc", 128'(next_pc), 128'(epc + 64'd4));
      chk(vr_idx == eidx, itag, 128'(vr_idx), 128'(eidx));
      chk(vr_data == ed, (w[20:16] == 5'd0) ? "R4 zero base data" : "R6 lane data", vr_data, ed);
      chk(rd_total - rd_mark == 16, "R5 read count", 128'(rd_total - rd_mark), 128'd16);
      chk(addr_log[rd_mark % 64] == ea, "R5 first address", 128'(addr_log[rd_mark % 64]), 128'(ea));
      chk(addr_log[(rd_mark + 15) % 64] == ea + 32'd15, "R5 last address",
          128'(addr_log[(rd_mark + 15) % 64]), 128'(ea + 32'd15));
   endtask

   task automatic do_load(input logic [31:0] w, input logic [6:0] eidx, input string itag);
      @(negedge clk);
      chk(gpr_ra_idx == w[20:16] || !start, "R4 base index", 128'(gpr_ra_idx), 128'(w[20:16]));
      launch(w);
      finish(w, eidx, itag, 1, pc);
      @(negedge clk);
      chk(!done && !vr_we, "R7 single pulse", 128'(done), 128'd0);
   endtask

   task automatic do_illegal(input logic [31:0] w);
      bool_loop: begin end
      @(negedge clk);
      launch(w);
      chk(illegal == 1'b1, "R3 flag", 128'(illegal), 128'd1);
      chk(busy == 1'b0 && mem_rd_en == 1'b0, "R3 no read", 128'({busy, mem_rd_en}), 128'd0);
      @(negedge clk);
      chk(illegal == 1'b0, "R3 one cycle", 128'(illegal), 128'd0);
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (done) chk(1'b0, "R3 no write", 128'(done), 128'd0);
      end
      chk(rd_total == rd_mark, "R3 no memory access", 128'(rd_total - rd_mark), 128'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL R7 watchdog expired act=%0d exp=%0d", 1, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] w, w2;
      repeat (3) @(negedge clk);
      // R9: reset state
      chk(!busy && !mem_rd_en && !done && !vr_we && !illegal, "R9 reset idle",
          128'({busy, mem_rd_en, done, vr_we, illegal}), 128'd0);
      rst = 1'b0;

      // R1, R10: classic form, every destination index
      for (int i = 0; i < 32; i++) begin
         salt = 64'(i) * 64'h0123_4567_89AB_CDEF;
         pc   = 64'h1000 + 64'(i) * 64'h40;
         w = 32'h7C00_02CE | (32'(i) << 21) | (32'((i * 7) % 32) << 16)
             | (32'(31 - i) << 11) | 32'(i % 2);
         do_load(w, 7'(i), (i % 2 == 1) ? "R10 classic with low bit set" : "R1 classic index");
      end

      // R2: extended form, every destination index
      for (int i = 0; i < 128; i++) begin
         salt = 64'(i) * 64'h9E37_79B9_7F4A_7C15;
         pc   = 64'hFFFF_FFFF_FFFF_FF00 + 64'(i);
         w = 32'h1000_02C3 | (32'(i % 32) << 21) | (32'(i / 32) << 2)
             | (32'((i * 3) % 32) << 16) | (32'((i * 5 + 1) % 32) << 11);
         do_load(w, 7'(i), "R2 extended index");
      end

      // R3: unrecognised words
      do_illegal(32'h0000_0000);
      do_illegal(32'hFFFF_FFFF);
      do_illegal(32'h7C00_02CC);
      do_illegal(32'h1000_02C0);
      do_illegal(32'h7C00_00CE);
      do_illegal(32'h1400_02C3);

      // R8: start while busy is ignored
      salt = 64'h55AA_1234_0F0F_8001;
      pc = 64'h2000;
      w  = 32'h7C00_02CE | (32'd9 << 21) | (32'd3 << 16) | (32'd4 << 11);
      w2 = 32'h1000_02C3 | (32'd1 << 21) | (32'd3 << 2);
      @(negedge clk);
      launch(w);
      repeat (3) @(negedge clk);
      chk(busy == 1'b1, "R8 busy during load", 128'(busy), 128'd1);
      start = 1'b1;
      insn = w2;
      @(negedge clk);
      start = 1'b0;
      finish(w, 7'd9, "R8 index kept", 5, 64'h2000);
      for (int i = 0; i < 25; i++) begin
         @(negedge clk);
         if (done) chk(1'b0, "R8 extra completion", 128'(done), 128'd0);
      end
      chk(rd_total - rd_mark == 16, "R8 read count", 128'(rd_total - rd_mark), 128'd16);

      // R11: start in the done cycle
      salt = 64'h0BAD_F00D_1357_9BDF;
      pc = 64'h3000;
      w  = 32'h7C00_02CE | (32'd17 << 21) | (32'd0 << 16) | (32'd12 << 11);
      w2 = 32'h1000_02C3 | (32'd30 << 21) | (32'd2 << 2) | (32'd6 << 16) | (32'd7 << 11);
      @(negedge clk);
      launch(w);
      finish(w, 7'd17, "R1 back to back first", 1, 64'h3000);
      pc = 64'h3004;
      launch(w2);
      finish(w2, 7'd94, "R11 back to back second", 1, 64'h3004);

      // R9: reset in the middle of a load
      @(negedge clk);
      launch(w);
      repeat (6) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(!busy && !mem_rd_en && !vr_we, "R9 reset mid load",
          128'({busy, mem_rd_en, vr_we}), 128'd0);
      for (int i = 0; i < 25; i++) begin
         @(negedge clk);
         if (done || mem_rd_en) chk(1'b0, "R9 no pending write", 128'({done, mem_rd_en}), 128'd0);
      end

      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule